// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the write-only configuration port of a data converter. An external controller drives three lines: an active-low select, a serial clock and a serial data line. All three lines are brought into the system clock domain through a synchronizer and then oversampled there. While select is low, the block shifts one data bit on each falling edge of the serial clock. Every sixteen bits form one word: an 8-bit address followed by an 8-bit value, each sent most significant bit first. A register is updated as soon as its sixteenth bit arrives. One select-low window can carry any number of words.

The register bank holds a small set of 8-bit configuration registers. The whole bank is exposed as one flat vector. Two things return every register to its reset value: the synchronous reset input, and a self-clearing reset bit in the control register. A priority stage combines the register contents with two four-level board straps, supplied here already decoded to 2-bit levels. From these it produces the effective reference selection, sample number format and output interface. A strap-only input makes the straps alone define all three settings, with no serial programming involved.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset, register 0x68 holds 0x08 and every other register holds 0x00. With both straps at level 0, all three effective outputs are 0.
- R2: Serial clock falling edges that occur while select is high shift no bits and write no register.
- R3: A word is the address byte followed by the data byte, both MSB first. The target register is written on the 16th falling edge of the window.
- R4: A single select-low window can write several registers, one for each complete 16-bit word.
- R5: If a window ends with fewer than 16 bits after the last complete word, those trailing bits are discarded and change no register.
- R6: The bit count restarts at zero whenever select goes high, so the next window starts on a word boundary.
- R7: A word to 0x6C with bit 1 set returns all registers to their reset values. That bit is never stored and always reads 0.
- R8: A word sent to an address outside {0x63, 0x68, 0x69, 0x6A, 0x6C, 0x6D} leaves every register unchanged.
- R9: Only defined bits are stored; all other bits read 0. The defined bits are: 0x63 bit 3, 0x68 bits 3:0, 0x69 bits 7:0, 0x6A bits 3:0, 0x6C bits 4:3, 0x6D bit 4. The flat vector carries, from its low byte upward, the registers 0x63, 0x68, 0x69, 0x6A, 0x6C, 0x6D.
- R10: In serial mode, `eff_offset_bin` follows 0x63 bit 3 when the format strap is at level 0. At levels 1, 2 and 3 it follows the strap instead, giving 0, 1 and 1 respectively.
- R11: In serial mode, `eff_ext_ref` follows 0x6D bit 4 when the reference strap is at level 0. At levels 1 and 2 it is 1, and at level 3 it is 0.
- R12: In serial mode, `eff_parallel` is 1 exactly when 0x6C bits 4:3 equal 11. The format strap has no effect on it.
- R13: In strap-only mode the format strap decodes as {offset, parallel}: level 0 gives {0,0}, level 1 gives {0,1}, level 2 gives {1,1} and level 3 gives {1,0}. The reference strap gives 1 at levels 1 and 2 and 0 at levels 0 and 3. Register contents are ignored.
- R14: Asserting reset at any time, including after registers have been written, restores the reset values of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (hardware reset) |
| ser_sel_n | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial clock, data taken on falling edge |
| ser_dat | input | 1 | Serial data |
| strap_only | input | 1 | 1: straps alone define the effective settings |
| fmt_strap | input | 2 | Decoded level of the format/interface strap |
| ref_strap | input | 2 | Decoded level of the reference strap |
| cfg_regs | output | 48 | Flat register bank, one byte per register |
| eff_ext_ref | output | 1 | Effective external reference select |
| eff_offset_bin | output | 1 | Effective offset binary (1) / two's complement (0) |
| eff_parallel | output | 1 | Effective parallel output (1) / DDR (0) |

## Verification
The following properties are checked on every cycle:
- The bit counter is cleared while select is high, and no word completes in that state.
- A completed word always lands on a counter wrap.
- A software reset word leaves the bank at its defaults.
- An unmapped word leaves the bank unchanged.
- Several strap levels force the outputs named in the priority rules.

The bench scenarios cover what a single-cycle property cannot show:
- MSB-first assembly of address and data.
- Multiple words in one window.
- A dropped partial tail followed by correct alignment in the next window.
- The per-register write masks.
- The full strap decode tables in both modes.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  localparam int NREG    = 6;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 16;
  localparam int FLAT_W  = NREG * BYTE_W;

  localparam logic [7:0] ADR_FMT  = 8'h63;
  localparam logic [7:0] ADR_GAIN = 8'h68;
  localparam logic [7:0] ADR_PLO  = 8'h69;
  localparam logic [7:0] ADR_PHI  = 8'h6A;
  localparam logic [7:0] ADR_CTL  = 8'h6C;
  localparam logic [7:0] ADR_REF  = 8'h6D;

  localparam int IDX_FMT = 0;
  localparam int IDX_CTL = 4;
  localparam int IDX_REF = 5;

  localparam int FMT_BIT  = 3;
  localparam int REF_BIT  = 4;
  localparam int SRST_BIT = 1;
  localparam int IF_LSB   = 3;

  localparam logic [1:0] LVL_0 = 2'd0;
  localparam logic [1:0] LVL_1 = 2'd1;
  localparam logic [1:0] LVL_2 = 2'd2;
  localparam logic [1:0] LVL_3 = 2'd3;

  function automatic logic [7:0] reg_addr(input int k);
    case (k)
      0:       return ADR_FMT;
      1:       return ADR_GAIN;
      2:       return ADR_PLO;
      3:       return ADR_PHI;
      4:       return ADR_CTL;
      default: return ADR_REF;
    endcase
  endfunction

  function automatic logic [7:0] reg_default(input int k);
    case (k)
      1:       return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reg_mask(input int k);
    case (k)
      0:       return 8'h08;
      1:       return 8'h0F;
      2:       return 8'hFF;
      3:       return 8'h0F;
      4:       return 8'h18;
      default: return 8'h10;
    endcase
  endfunction

  function automatic logic [FLAT_W-1:0] default_flat();
    logic [FLAT_W-1:0] v;
    v = '0;
    for (int k = 0; k < NREG; k++) v[k*BYTE_W +: BYTE_W] = reg_default(k);
    return v;
  endfunction

endpackage

// File: rtl/cfg_line_sync.sv
module cfg_line_sync #(
  parameter int         WIDTH   = 3,
  parameter int         STAGES  = 2,
  parameter logic [2:0] RST_VAL = 3'b100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= RST_VAL[WIDTH-1:0];
        else if (s == 0) stage_q[s] <= din;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/cfg_word_rx.sv
module cfg_word_rx
  import cfg_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_n,
  input  logic       sclk,
  input  logic       sdat,
  output logic       word_vld,
  output logic [7:0] word_addr,
  output logic [7:0] word_data
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              sclk_d;
  logic              fall;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-2:0] shreg;
  logic [WORD_W-1:0] word_q;

  assign fall = sclk_d & ~sclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b0;
      bit_cnt  <= '0;
      shreg    <= '0;
      word_vld <= 1'b0;
      word_q   <= '0;
    end else begin
      sclk_d   <= sclk;
      word_vld <= 1'b0;
      if (sel_n) begin
        bit_cnt <= '0;
      end else if (fall) begin
        shreg   <= {shreg[WORD_W-3:0], sdat};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST) begin
          word_vld <= 1'b1;
          word_q   <= {shreg, sdat};
        end
      end
    end
  end

  assign word_addr = word_q[WORD_W-1:BYTE_W];
  assign word_data = word_q[BYTE_W-1:0];

  AST_CNT_CLEAR_ON_SEL: assert property (@(posedge clk) disable iff (rst)
    sel_n |=> (bit_cnt == '0)); // R6
  AST_NO_WORD_SEL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sel_n && $past(sel_n)) |-> !word_vld); // R2
  AST_WORD_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> (bit_cnt == '0)); // R3

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_vld,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic [FLAT_W-1:0] regs_flat
);

  localparam logic [FLAT_W-1:0] DEF_FLAT = default_flat();

  logic [NREG-1:0] hit;
  logic            soft_rst;

  assign soft_rst = wr_vld && (wr_addr == ADR_CTL) && wr_data[SRST_BIT];

  generate
    for (genvar k = 0; k < NREG; k++) begin : g_reg
      localparam logic [7:0] ADR  = reg_addr(k);
      localparam logic [7:0] DEFV = reg_default(k);
      localparam logic [7:0] MSK  = reg_mask(k);
      logic [7:0] q;

      assign hit[k] = wr_vld && (wr_addr == ADR);

      always_ff @(posedge clk) begin
        if (rst || soft_rst) q <= DEFV;
        else if (hit[k])     q <= wr_data & MSK;
      end

      assign regs_flat[k*BYTE_W +: BYTE_W] = q;
    end
  endgenerate

  AST_SOFT_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (regs_flat == DEF_FLAT)); // R7
  AST_UNMAPPED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_vld && (hit == '0)) |=> $stable(regs_flat)); // R8
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit)); // R3

endmodule

// File: rtl/cfg_strap_merge.sv
module cfg_strap_merge
  import cfg_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       strap_only,
  input  logic [1:0] fmt_strap,
  input  logic [1:0] ref_strap,
  input  logic       reg_offset,
  input  logic [1:0] reg_iface,
  input  logic       reg_ext_ref,
  output logic       eff_ext_ref,
  output logic       eff_offset_bin,
  output logic       eff_parallel
);

  logic s_off, s_par, s_ext;
  logic n_off, n_par, n_ext;

  always_comb begin
    case (fmt_strap)
      LVL_0:   begin s_off = 1'b0; s_par = 1'b0; end
      LVL_1:   begin s_off = 1'b0; s_par = 1'b1; end
      LVL_2:   begin s_off = 1'b1; s_par = 1'b1; end
      default: begin s_off = 1'b1; s_par = 1'b0; end
    endcase
    s_ext = (ref_strap == LVL_1) || (ref_strap == LVL_2);

    if (strap_only) begin
      n_off = s_off;
      n_par = s_par;
      n_ext = s_ext;
    end else begin
      n_off = (fmt_strap == LVL_0) ? reg_offset : s_off;
      n_par = (reg_iface == 2'b11);
      n_ext = (ref_strap == LVL_0) ? reg_ext_ref : s_ext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_ext_ref    <= 1'b0;
      eff_offset_bin <= 1'b0;
      eff_parallel   <= 1'b0;
    end else begin
      eff_ext_ref    <= n_ext;
      eff_offset_bin <= n_off;
      eff_parallel   <= n_par;
    end
  end

  AST_FMT_STRAP_OVERRIDES: assert property (@(posedge clk) disable iff (rst)
    (!strap_only && fmt_strap == LVL_2) |=> eff_offset_bin); // R10
  AST_REF_STRAP_OVERRIDES: assert property (@(posedge clk) disable iff (rst)
    (!strap_only && ref_strap == LVL_1) |=> eff_ext_ref); // R11
  AST_IFACE_FROM_REG: assert property (@(posedge clk) disable iff (rst)
    (!strap_only && reg_iface == 2'b00) |=> !eff_parallel); // R12
  AST_STRAP_ONLY_LVL3: assert property (@(posedge clk) disable iff (rst)
    (strap_only && fmt_strap == LVL_3) |=> (eff_offset_bin && !eff_parallel)); // R13

endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_sel_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              strap_only,
  input  logic [1:0]        fmt_strap,
  input  logic [1:0]        ref_strap,
  output logic [FLAT_W-1:0] cfg_regs,
  output logic              eff_ext_ref,
  output logic              eff_offset_bin,
  output logic              eff_parallel
);

  logic [2:0] lines_s;
  logic       wr_vld;
  logic [7:0] wr_addr, wr_data;

  cfg_line_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({ser_sel_n, ser_clk, ser_dat}),
    .dout(lines_s)
  );

  cfg_word_rx u_rx (
    .clk      (clk),
    .rst      (rst),
    .sel_n    (lines_s[2]),
    .sclk     (lines_s[1]),
    .sdat     (lines_s[0]),
    .word_vld (wr_vld),
    .word_addr(wr_addr),
    .word_data(wr_data)
  );

  cfg_reg_bank u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_vld   (wr_vld),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .regs_flat(cfg_regs)
  );

  cfg_strap_merge u_merge (
    .clk           (clk),
    .rst           (rst),
    .strap_only    (strap_only),
    .fmt_strap     (fmt_strap),
    .ref_strap     (ref_strap),
    .reg_offset    (cfg_regs[IDX_FMT*BYTE_W + FMT_BIT]),
    .reg_iface     (cfg_regs[IDX_CTL*BYTE_W + IF_LSB +: 2]),
    .reg_ext_ref   (cfg_regs[IDX_REF*BYTE_W + REF_BIT]),
    .eff_ext_ref   (eff_ext_ref),
    .eff_offset_bin(eff_offset_bin),
    .eff_parallel  (eff_parallel)
  );

  AST_SRST_BIT_NEVER_STORED: assert property (@(posedge clk) disable iff (rst)
    !cfg_regs[IDX_CTL*BYTE_W + SRST_BIT]); // R7

endmodule

// File: tb/test_cfg_serial_port.sv
module test_cfg_serial_port;

  localparam int HB = 5;
  localparam logic [47:0] DEF = 48'h0000_0000_0800;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_sel_n = 1'b1;
  logic        ser_clk = 1'b0;
  logic        ser_dat = 1'b0;
  logic        strap_only = 1'b0;
  logic [1:0]  fmt_strap = 2'd0;
  logic [1:0]  ref_strap = 2'd0;
  logic [47:0] cfg_regs;
  logic        eff_ext_ref, eff_offset_bin, eff_parallel;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cfg_serial_port i_cfg_serial_port (
    .clk(clk), .rst(rst), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .strap_only(strap_only), .fmt_strap(fmt_strap),
    .ref_strap(ref_strap), .cfg_regs(cfg_regs), .eff_ext_ref(eff_ext_ref),
    .eff_offset_bin(eff_offset_bin), .eff_parallel(eff_parallel)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b;
    wait_n(HB);
    ser_clk = 1'b1;
    wait_n(HB);
    ser_clk = 1'b0;
    wait_n(HB);
  endtask

  task automatic open_win();
    ser_sel_n = 1'b0;
    wait_n(4);
  endtask

  task automatic close_win();
    ser_sel_n = 1'b1;
    wait_n(12);
  endtask

  task automatic send_word(input logic [7:0] a, input logic [7:0] d);
    logic [15:0] w;
    w = {a, d};
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic write1(input logic [7:0] a, input logic [7:0] d);
    open_win();
    send_word(a, d);
    close_win();
  endtask

  task automatic set_straps(input logic so, input logic [1:0] f, input logic [1:0] r);
    strap_only = so;
    fmt_strap  = f;
    ref_strap  = r;
    wait_n(4);
  endtask

  task automatic t_reset();
    check("R1 regs", cfg_regs, DEF);
    check("R1 eff", {eff_ext_ref, eff_offset_bin, eff_parallel}, 3'b000);
  endtask

  task automatic t_single();
    write1(8'h69, 8'hA5);
    check("R3 plo", cfg_regs[23:16], 8'hA5);
    check("R3 rest", {cfg_regs[47:24], cfg_regs[15:0]}, {24'h0, 16'h0800});
  endtask

  task automatic t_multi();
    open_win();
    send_word(8'h6A, 8'hFF);
    send_word(8'h68, 8'h03);
    close_win();
    check("R9 phi mask", cfg_regs[31:24], 8'h0F);
    check("R4 gain", cfg_regs[15:8], 8'h03);
  endtask

  task automatic t_partial();
    logic [47:0] snap;
    open_win();
    send_word(8'h69, 8'h3C);
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    close_win();
    check("R5 last word", cfg_regs[23:16], 8'h3C);
    snap = cfg_regs;
    open_win();
    send_word(8'h69, 8'h5A);
    close_win();
    check("R6 realigned", cfg_regs[23:16], 8'h5A);
    check("R6 others", {cfg_regs[47:24], cfg_regs[15:0]}, {snap[47:24], snap[15:0]});
  endtask

  task automatic t_sel_high();
    for (int i = 15; i >= 0; i--) send_bit(i[0]);
    wait_n(12);
    check("R2 no write", cfg_regs[23:16], 8'h5A);
  endtask

  task automatic t_unmapped();
    logic [47:0] snap;
    snap = cfg_regs;
    write1(8'h64, 8'hFF);
    write1(8'hE9, 8'hFF);
    check("R8 unmapped", cfg_regs, snap);
  endtask

  task automatic t_masks();
    write1(8'h63, 8'hFF);
    write1(8'h6D, 8'hFF);
    check("R9 fmt", cfg_regs[7:0], 8'h08);
    check("R9 ref", cfg_regs[47:40], 8'h10);
    write1(8'h6C, 8'hFD);
    check("R9 ctl", cfg_regs[39:32], 8'h18);
  endtask

  task automatic t_fmt();
    write1(8'h6C, 8'h00);
    write1(8'h63, 8'h08);
    set_straps(1'b0, 2'd0, 2'd0);
    check("R10 lvl0 reg1", eff_offset_bin, 1'b1);
    set_straps(1'b0, 2'd1, 2'd0);
    check("R10 lvl1", eff_offset_bin, 1'b0);
    set_straps(1'b0, 2'd2, 2'd0);
    check("R10 lvl2", eff_offset_bin, 1'b1);
    set_straps(1'b0, 2'd3, 2'd0);
    check("R10 lvl3", eff_offset_bin, 1'b1);
    write1(8'h63, 8'h00);
    set_straps(1'b0, 2'd0, 2'd0);
    check("R10 lvl0 reg0", eff_offset_bin, 1'b0);
  endtask

  task automatic t_ref();
    write1(8'h6D, 8'h10);
    set_straps(1'b0, 2'd0, 2'd0);
    check("R11 lvl0 reg1", eff_ext_ref, 1'b1);
    set_straps(1'b0, 2'd0, 2'd3);
    check("R11 lvl3", eff_ext_ref, 1'b0);
    write1(8'h6D, 8'h00);
    set_straps(1'b0, 2'd0, 2'd2);
    check("R11 lvl2", eff_ext_ref, 1'b1);
    set_straps(1'b0, 2'd0, 2'd1);
    check("R11 lvl1", eff_ext_ref, 1'b1);
    set_straps(1'b0, 2'd0, 2'd0);
    check("R11 lvl0 reg0", eff_ext_ref, 1'b0);
  endtask

  task automatic t_iface();
    write1(8'h6C, 8'h18);
    set_straps(1'b0, 2'd0, 2'd0);
    check("R12 par strap0", eff_parallel, 1'b1);
    set_straps(1'b0, 2'd3, 2'd0);
    check("R12 par strap3", eff_parallel, 1'b1);
    write1(8'h6C, 8'h08);
    set_straps(1'b0, 2'd1, 2'd0);
    check("R12 ddr strap1", eff_parallel, 1'b0);
  endtask

  task automatic t_strap_only();
    write1(8'h63, 8'h08);
    write1(8'h6C, 8'h18);
    write1(8'h6D, 8'h10);
    set_straps(1'b1, 2'd0, 2'd0);
    check("R13 f0 r0", {eff_offset_bin, eff_parallel, eff_ext_ref}, 3'b000);
    set_straps(1'b1, 2'd1, 2'd1);
    check("R13 f1 r1", {eff_offset_bin, eff_parallel, eff_ext_ref}, 3'b011);
    set_straps(1'b1, 2'd2, 2'd2);
    check("R13 f2 r2", {eff_offset_bin, eff_parallel, eff_ext_ref}, 3'b111);
    set_straps(1'b1, 2'd3, 2'd3);
    check("R13 f3 r3", {eff_offset_bin, eff_parallel, eff_ext_ref}, 3'b100);
    set_straps(1'b0, 2'd0, 2'd0);
  endtask

  task automatic t_soft();
    write1(8'h68, 8'h0E);
    write1(8'h6C, 8'h1A);
    check("R7 defaults", cfg_regs, DEF);
    check("R7 eff", {eff_ext_ref, eff_offset_bin, eff_parallel}, 3'b000);
  endtask

  task automatic t_hw();
    write1(8'h69, 8'h77);
    write1(8'h6D, 8'h10);
    @(negedge clk);
    rst = 1'b1;
    wait_n(3);
    rst = 1'b0;
    wait_n(3);
    check("R14 defaults", cfg_regs, DEF);
    check("R14 eff", {eff_ext_ref, eff_offset_bin, eff_parallel}, 3'b000);
  endtask

  initial begin
    wait_n(5);
    rst = 1'b0;
    wait_n(5);
    t_reset();
    t_single();
    t_multi();
    t_partial();
    t_sel_high();
    t_unmapped();
    t_masks();
    t_fmt();
    t_ref();
    t_iface();
    t_strap_only();
    t_soft();
    t_hw();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule